// File: doc/BRIEF.md
# Prefixed Bit and Shift Unit

This unit executes the second byte of a prefixed opcode on one 8-bit value. Every one of the 256 codes is decoded from its bit fields. The low three bits pick the operand. The top two bits pick one of four operation groups:

- a rotate or shift family,
- a single-bit test,
- a single-bit clear,
- a single-bit set.

The middle three bits pick either the rotate or shift kind, or the bit number. The unit returns four things: the result, a write-back enable, the next flag set, and the operand selector. The sequencer uses the selector to find the register to read and write, and it fetches memory first when the operand lives in memory.

A separate short-form mode serves the four one-byte accumulator rotates. In this mode the operand is always the accumulator, and the zero flag is always cleared.

The datapath is purely combinational. A parameter places an optional register on the outputs; by default it is present and gives one cycle of latency, marked by an output valid bit.

Top module: `prefix_bitshift_unit`

## Requirements
- R1: The operand selector output equals opcode bits 2:0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory addressed by HL, 7 A). The memory indicator is high exactly when the selector is 6.
- R2: Opcode bits 7:6 choose the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. For groups 01 to 11, bits 5:3 give the bit number, with 0 as the least significant bit.
- R3: In group 00, bits 5:3 values 0 to 3 select, in order: rotate left circular, rotate right circular, rotate left through carry, rotate right through carry.
  - The circular forms feed the outgoing bit back in at the other end.
  - The through-carry forms feed in the old carry.
  - All four put the outgoing bit into carry.
- R4: Bits 5:3 values 4, 5 and 7 select, in order:
  - Shift left: fills bit 0 with 0.
  - Arithmetic shift right: keeps bit 7.
  - Logical shift right: fills bit 7 with 0.
  - Carry takes the bit shifted out in all three.
  - All rotates and shifts set Z when the result is zero and clear N and H.
- R5: Bits 5:3 value 6 exchanges the two nibbles, sets Z from the result and clears N, H and C.
- R6: Bit test sets Z when the chosen bit is 0, clears N, sets H, keeps C, and deasserts the write enable.
- R7: Bit clear and bit set change only the chosen bit, assert the write enable and pass all four flags through unchanged.
- R8: With the accumulator mode input high:
  - opcode bits 4:3 select one of the four R3 rotates;
  - the selector is 7 and the memory indicator is low;
  - the write enable is high;
  - Z is forced to 0;
  - the other opcode bits are ignored.
- R9: With the output register present, results appear on the cycle after an input valid, with output valid high. Reset clears the output valid, the write enable, the result, the flags, the selector and the memory indicator.
- Flag encoding on the flag ports: bit 3 Z, bit 2 N, bit 1 H, bit 0 C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Current inputs carry an operation |
| opByte | input | 8 | Prefixed opcode byte |
| accMode | input | 1 | Short-form accumulator rotate mode |
| operand | input | 8 | Operand value |
| flagsIn | input | 4 | Incoming flags {Z,N,H,C} |
| outValid | output | 1 | Outputs carry a result |
| regSel | output | 3 | Operand selector |
| memOp | output | 1 | Operand is in memory |
| result | output | 8 | Value to write back |
| wrEn | output | 1 | Write the result back |
| flagsOut | output | 4 | Next flags {Z,N,H,C} |

## Verification
A wrong decode shows up at the ports on the very next valid cycle as one of three symptoms:
- a wrong selector,
- a write enable raised on a bit test,
- a flag changed by a set or clear.

A wrong fill bit in a rotate or shift differs from the expected result only for operands whose edge bits are set, or when the carry-in is 1. For that reason, every opcode is swept with operands holding the edge bits, mixed patterns and zero, under both carry values. Accumulator mode is swept separately, because there a zero result must still leave Z clear.

// File: rtl/bsu_pkg.sv
`timescale 1ns/1ps
package bsu_pkg;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC  = 3'd0,
    SH_RRC  = 3'd1,
    SH_RL   = 3'd2,
    SH_RR   = 3'd3,
    SH_SLA  = 3'd4,
    SH_SRA  = 3'd5,
    SH_SWAP = 3'd6,
    SH_SRL  = 3'd7
  } shop_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic       doShift;
    logic       doTest;
    logic       doClr;
    logic       doSet;
    shop_e      shiftOp;
    logic [2:0] bitIdx;
    logic       zMask;
  } dpCtrl_t;

  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_ACC = 3'd7;

endpackage

// File: rtl/bsu_ctrl.sv
`timescale 1ns/1ps
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic [7:0] opByte,
  input  logic       accMode,
  output dpCtrl_t    dpCtrl,
  output logic [2:0] regSel,
  output logic       memOp,
  output logic       wrEn
);

  grp_e grp;
  assign grp = grp_e'(opByte[7:6]);

  always_comb begin
    dpCtrl = '0;
    regSel = '0;
    memOp  = 1'b0;
    wrEn   = 1'b0;
    if (accMode) begin
      // short form: accumulator rotates only, zero flag forced low
      dpCtrl.doShift = 1'b1;
      dpCtrl.shiftOp = shop_e'({1'b0, opByte[4:3]});
      dpCtrl.zMask   = 1'b1;
      regSel         = SEL_ACC;
      wrEn           = 1'b1;
    end else begin
      regSel        = opByte[2:0];
      memOp         = (opByte[2:0] == SEL_MEM);
      dpCtrl.bitIdx = opByte[5:3];
      unique case (grp)
        GRP_SHIFT: begin
          dpCtrl.doShift = 1'b1;
          dpCtrl.shiftOp = shop_e'(opByte[5:3]);
          wrEn           = 1'b1;
        end
        GRP_TEST: dpCtrl.doTest = 1'b1;
        GRP_CLR: begin
          dpCtrl.doClr = 1'b1;
          wrEn         = 1'b1;
        end
        GRP_SET: begin
          dpCtrl.doSet = 1'b1;
          wrEn         = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bsu_datapath.sv
`timescale 1ns/1ps
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int W = 8
) (
  input  dpCtrl_t        dpCtrl,
  input  logic [W-1:0]   operand,
  input  flags_t         flagsIn,
  output logic [W-1:0]   result,
  output flags_t         flagsOut
);

  localparam int HALF = W / 2;

  logic [W-1:0] bitMask;
  logic         selBit;
  logic [W-1:0] shOut;
  logic         shCarry;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign bitMask[i] = (dpCtrl.bitIdx == 3'(i));
  end

  assign selBit = |(operand & bitMask);

  always_comb begin
    shOut   = operand;
    shCarry = 1'b0;
    unique case (dpCtrl.shiftOp)
      SH_RLC: begin
        shOut   = {operand[W-2:0], operand[W-1]};
        shCarry = operand[W-1];
      end
      SH_RRC: begin
        shOut   = {operand[0], operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_RL: begin
        shOut   = {operand[W-2:0], flagsIn.c};
        shCarry = operand[W-1];
      end
      SH_RR: begin
        shOut   = {flagsIn.c, operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_SLA: begin
        shOut   = {operand[W-2:0], 1'b0};
        shCarry = operand[W-1];
      end
      SH_SRA: begin
        shOut   = {operand[W-1], operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_SWAP: begin
        shOut   = {operand[HALF-1:0], operand[W-1:HALF]};
        shCarry = 1'b0;
      end
      SH_SRL: begin
        shOut   = {1'b0, operand[W-1:1]};
        shCarry = operand[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    result   = operand;
    flagsOut = flagsIn;
    if (dpCtrl.doShift) begin
      result     = shOut;
      flagsOut.z = (shOut == '0) & ~dpCtrl.zMask;
      flagsOut.n = 1'b0;
      flagsOut.h = 1'b0;
      flagsOut.c = shCarry;
    end else if (dpCtrl.doTest) begin
      flagsOut.z = ~selBit;
      flagsOut.n = 1'b0;
      flagsOut.h = 1'b1;
    end else if (dpCtrl.doClr) begin
      result = operand & ~bitMask;
    end else if (dpCtrl.doSet) begin
      result = operand | bitMask;
    end
  end

endmodule

// File: rtl/prefix_bitshift_unit.sv
`timescale 1ns/1ps
module prefix_bitshift_unit
  import bsu_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   opByte,
  input  logic         accMode,
  input  logic [W-1:0] operand,
  input  logic [3:0]   flagsIn,
  output logic         outValid,
  output logic [2:0]   regSel,
  output logic         memOp,
  output logic [W-1:0] result,
  output logic         wrEn,
  output logic [3:0]   flagsOut
);

  localparam int HALF = W / 2;

  dpCtrl_t      dpCtrl;
  logic [2:0]   selComb;
  logic         memComb;
  logic         wrComb;
  logic [W-1:0] resComb;
  flags_t       flagsComb;

  bsu_ctrl u_ctrl (
    .opByte (opByte),
    .accMode(accMode),
    .dpCtrl (dpCtrl),
    .regSel (selComb),
    .memOp  (memComb),
    .wrEn   (wrComb)
  );

  bsu_datapath #(.W(W)) u_dp (
    .dpCtrl  (dpCtrl),
    .operand (operand),
    .flagsIn (flags_t'(flagsIn)),
    .result  (resComb),
    .flagsOut(flagsComb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid <= 1'b0;
        regSel   <= '0;
        memOp    <= 1'b0;
        result   <= '0;
        wrEn     <= 1'b0;
        flagsOut <= '0;
      end else begin
        outValid <= inValid;
        regSel   <= selComb;
        memOp    <= memComb & inValid;
        result   <= resComb;
        wrEn     <= wrComb & inValid;
        flagsOut <= flagsComb;
      end
    end

    AST_MEM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (memOp == (regSel == SEL_MEM))); // R1
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !accMode && opByte[7:6] == 2'b01) |=> (outValid && !wrEn)); // R6
    AST_SETCLR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !accMode && opByte[7]) |=> (flagsOut == $past(flagsIn))); // R7
    AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !accMode && opByte[7:3] == 5'b00110) |=>
        (result == {$past(operand[HALF-1:0]), $past(operand[W-1:HALF])} && !flagsOut[0])); // R5
    AST_ACC_Z_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && accMode) |=> (!flagsOut[3] && regSel == SEL_ACC && !memOp)); // R8
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid); // R9
  end else begin : g_comb
    assign outValid = inValid;
    assign regSel   = selComb;
    assign memOp    = memComb & inValid;
    assign result   = resComb;
    assign wrEn     = wrComb & inValid;
    assign flagsOut = flagsComb;
  end

endmodule

// File: tb/prefix_bitshift_unit_bench.sv
`timescale 1ns/1ps
module prefix_bitshift_unit_bench;

  typedef struct packed {
    logic [2:0] sel;
    logic       mem;
    logic       wr;
    logic [7:0] res;
    logic [3:0] fl;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] opByte = '0;
  logic       accMode = 1'b0;
  logic [7:0] operand = '0;
  logic [3:0] flagsIn = '0;
  logic       outValid;
  logic [2:0] regSel;
  logic       memOp;
  logic [7:0] result;
  logic       wrEn;
  logic [3:0] flagsOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  exp_t  expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  prefix_bitshift_unit u_prefix_bitshift_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opByte(opByte),
    .accMode(accMode), .operand(operand), .flagsIn(flagsIn),
    .outValid(outValid), .regSel(regSel), .memOp(memOp),
    .result(result), .wrEn(wrEn), .flagsOut(flagsOut)
  );

  // Reference model written from the requirements; flags {Z,N,H,C}
  function automatic exp_t model(input logic [7:0] op, input logic acc,
                                 input logic [7:0] a, input logic [3:0] fl);
    exp_t e;
    logic [2:0] kind;
    logic [2:0] idx;
    logic co;
    logic cin;
    cin = fl[0];
    idx = op[5:3];
    co  = 1'b0;
    e.res = a;
    e.fl  = fl;
    e.wr  = 1'b1;
    if (acc) begin
      e.sel = 3'd7; e.mem = 1'b0; kind = {1'b0, op[4:3]};
    end else begin
      e.sel = op[2:0]; e.mem = (op[2:0] == 3'd6); kind = op[5:3];
    end
    if (acc || op[7:6] == 2'b00) begin
      case (kind)
        3'd0: begin e.res = (a << 1) | (a >> 7); co = a[7]; end
        3'd1: begin e.res = (a >> 1) | (a << 7); co = a[0]; end
        3'd2: begin e.res = (a << 1) | {7'd0, cin}; co = a[7]; end
        3'd3: begin e.res = (a >> 1) | {cin, 7'd0}; co = a[0]; end
        3'd4: begin e.res = a << 1; co = a[7]; end
        3'd5: begin e.res = 8'($signed(a) >>> 1); co = a[0]; end
        3'd6: begin e.res = (a << 4) | (a >> 4); co = 1'b0; end
        default: begin e.res = a >> 1; co = a[0]; end
      endcase
      e.fl = {(acc ? 1'b0 : (e.res == 8'd0)), 1'b0, 1'b0, co};
    end else if (op[7:6] == 2'b01) begin
      e.wr = 1'b0;
      e.fl = {~a[idx], 1'b0, 1'b1, cin};
    end else if (op[7:6] == 2'b10) begin
      e.res = a & ~(8'd1 << idx);
    end else begin
      e.res = a | (8'd1 << idx);
    end
    return e;
  endfunction

  function automatic string tagOf(input logic [7:0] op, input logic acc);
    if (acc) return "R8";
    if (op[7:6] == 2'b01) return "R6";
    if (op[7]) return "R7";
    if (op[5:3] == 3'd6) return "R5";
    if (op[5]) return "R4";
    return "R3";
  endfunction

  task automatic send(input logic [7:0] op, input logic acc,
                      input logic [7:0] a, input logic [3:0] fl, input string tag);
    @(negedge clk);
    opByte = op; accMode = acc; operand = a; flagsIn = fl; inValid = 1'b1;
    expQ.push_back(model(op, acc, a, fl));
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: outputs registered at posedge, sampled at the following negedge (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R9: result with no expected item, act=%h", result);
        end else begin
          exp_t e;
          exp_t act;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          act = {regSel, memOp, wrEn, result, flagsOut};
          if (act !== e) begin
            mismatched++;
            $display("FAIL %s: act sel=%0d mem=%b wr=%b res=%h fl=%b exp sel=%0d mem=%b wr=%b res=%h fl=%b",
                     t, act.sel, act.mem, act.wr, act.res, act.fl,
                     e.sel, e.mem, e.wr, e.res, e.fl);
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finishRun();
  end

  initial begin
    logic [7:0] pats[5];
    pats = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'h5A};
    repeat (3) @(negedge clk);
    // R9 reset state
    compared++;
    if (outValid !== 1'b0 || wrEn !== 1'b0 || result !== 8'h00 || flagsOut !== 4'h0 ||
        memOp !== 1'b0 || regSel !== 3'd0) begin
      mismatched++;
      $display("FAIL R9: reset act v=%b wr=%b res=%h fl=%b exp all zero",
               outValid, wrEn, result, flagsOut);
    end
    @(negedge clk);
    rstN = 1'b1;

    // Directed corner cases
    send(8'h10, 1'b0, 8'h80, 4'b0001, "R3 RL carry in");     // res 01, C=1
    send(8'h00, 1'b0, 8'h00, 4'b0000, "R3 RLC zero");        // Z=1
    send(8'h1F, 1'b0, 8'h01, 4'b0001, "R3 RR carry in");     // res 80, C=1
    send(8'h28, 1'b0, 8'h81, 4'b0000, "R4 SRA keeps msb");   // res C0, C=1
    send(8'h38, 1'b0, 8'h01, 4'b0000, "R4 SRL to zero");     // res 00, Z=1, C=1
    send(8'h20, 1'b0, 8'h80, 4'b0000, "R4 SLA to zero");     // res 00, Z=1, C=1
    send(8'h37, 1'b0, 8'hF0, 4'b0111, "R5 swap clears");     // res 0F, flags 0
    send(8'h7E, 1'b0, 8'h7F, 4'b0001, "R6 bit7 clear mem");  // Z=1 H=1 C kept, mem
    send(8'h46, 1'b0, 8'h01, 4'b1000, "R6 bit0 set");        // Z=0
    send(8'hBE, 1'b0, 8'hFF, 4'b1011, "R7 clear bit7");      // res 7F flags kept
    send(8'hC0, 1'b0, 8'h00, 4'b0100, "R7 set bit0");        // res 01
    send(8'h00, 1'b1, 8'h00, 4'b0000, "R8 acc zero result"); // Z forced 0
    send(8'hFE, 1'b1, 8'h01, 4'b0001, "R8 acc bits ignored");// RR with carry
    idle();
    repeat (2) @(negedge clk);

    // Sweep: every opcode, R1 selector and R2 group/bit decode
    for (int op = 0; op < 256; op++) begin
      for (int p = 0; p < 5; p++) begin
        for (int c = 0; c < 2; c++) begin
          send(8'(op), 1'b0, pats[p], {1'b0, 1'b1, 1'(c), 1'(c)},
               $sformatf("R1 R2 %s op=%h", tagOf(8'(op), 1'b0), op));
        end
      end
    end
    // Accumulator mode sweep with varied ignored bits
    for (int op = 0; op < 256; op += 7) begin
      for (int p = 0; p < 5; p++) begin
        send(8'(op), 1'b1, pats[p], {1'b1, 1'b0, 1'b1, 1'(p % 2)},
             $sformatf("%s op=%h", tagOf(8'(op), 1'b1), op));
      end
    end
    idle();
    repeat (4) @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R9: pending act=%0d exp=0", expQ.size());
    end
    finishRun();
  end

endmodule